// File: doc/BRIEF.md
# Loop Trip-Count Side Predictor

This block sits beside a direction predictor and watches backward (loop back-edge) branches. For each loop it follows, it counts how many times the back-edge is taken before the branch falls through. Once two invocations in a row end after the same count, it replaces the base prediction with its own: taken on every execution except the last, and not-taken on the exit execution. This removes the exit misprediction that a saturating-counter predictor always makes.

The block has two strobed ports. The lookup port gives the fetch PC, a backward-branch flag and the base predictor's direction. It returns the final direction and a flag that says whether the loop table overrode the base. The result is combinational. The update port reports each resolved branch: its PC, its outcome and a backward flag. It writes the table on the rising clock edge. Both ports take one transaction per cycle and accept every one, so they have no ready signal and no back-pressure. A strobe that is low in a cycle means that port carries no transaction. The table has 8 fully associative entries, each tagged by the full PC.

Top module: `loop_trip_predictor`

## Requirements
- R1: After reset the table holds no entries, so `pred_override` is 0 and `pred_taken` equals `lkp_base_taken` for every lookup.
- R2: A new entry is allocated only by a valid update with `upd_backward`=1 and `upd_taken`=1 whose PC misses. An update with `upd_backward`=0 changes nothing, and a not-taken update that misses allocates nothing.
- R3: A new entry starts with an iteration count of 1. Each taken update that hits adds 1 to the count. A taken update that hits an entry whose 10-bit count is already 1023 removes the entry.
- R4: A not-taken update that hits ends an invocation. The entry's count of taken outcomes becomes its learned trip value, and the count returns to 0. The entry becomes confident only if the previous learned value was nonzero and equals the new one.
- R5: A valid backward lookup that hits a confident entry sets `pred_override`=1. `pred_taken` is 1 while the iteration count is below the learned value and 0 when the count equals or exceeds it, which is the exit execution.
- R6: An invocation that ends with a count different from the learned value clears confidence. Lookups then return the base direction with `pred_override`=0.
- R7: An invocation of fewer than 4 executions (fewer than 3 taken outcomes before the not-taken one) removes the entry. An invocation of exactly 4 executions is kept.
- R8: An allocation uses the lowest-numbered free entry. If no entry is free, it evicts the entry least recently written by an update, where any update that hits or allocates counts as a write.
- R9: A lookup and an update for the same PC in the same cycle: the lookup sees the table as it was before that update.
- R10: A lookup with `lkp_valid`=0 or `lkp_backward`=0 never overrides. `pred_taken` then equals `lkp_base_taken`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup strobe |
| lkp_pc | input | 32 | Lookup branch PC |
| lkp_backward | input | 1 | Lookup branch is a backward branch |
| lkp_base_taken | input | 1 | Direction from the base predictor |
| pred_taken | output | 1 | Final predicted direction |
| pred_override | output | 1 | 1 when the loop table supplied `pred_taken` |
| upd_valid | input | 1 | Update strobe |
| upd_pc | input | 32 | Resolved branch PC |
| upd_backward | input | 1 | Resolved branch is a backward branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The interesting collision is a lookup and an update of the same loop PC in one cycle. The update advances or closes the iteration count, while the lookup must still report the count as it stood before the edge. The bench drives every loop execution with both ports aimed at the same PC in the same cycle. It also puts a taken update next to a lookup at the count just below the learned value. It then checks that the combinational answer in that cycle reflects the old count (taken) and that the lookup-only probe in the next cycle sees the exit (not-taken). A behavioural model of the table is compared against both outputs every cycle.

// File: rtl/lp_pkg.sv
package lp_pkg;
  parameter int LP_PC_W  = 32;
  parameter int LP_CNT_W = 10;

  typedef struct packed {
    logic                vld;
    logic                conf;
    logic [LP_PC_W-1:0]  tag;
    logic [LP_CNT_W-1:0] trip;
    logic [LP_CNT_W-1:0] iter;
  } lp_entry_t;
endpackage

// File: rtl/lp_cam.sv
module lp_cam #(
  parameter int N  = 8,
  parameter int W  = 32,
  parameter int IW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   vld,
  input  logic [N*W-1:0] tags,
  input  logic [W-1:0]   key,
  output logic [N-1:0]   hits,
  output logic           any,
  output logic [IW-1:0]  idx
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign hits[g] = vld[g] && (tags[g*W +: W] == key);
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++)
      if (hits[i]) idx = IW'(i);
  end

  assign any = |hits;

  // R2: allocation only on a miss keeps each tag unique
  a_r2_tag_unique: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hits));
endmodule

// File: rtl/lp_repl.sv
module lp_repl #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vld,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim
);
  logic [IW-1:0] age [N];
  logic [N-1:0]  oldest;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)          age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < N; i++) begin
      oldest[i] = (age[i] == IW'(N-1));
      if (oldest[i]) victim = IW'(i);
    end
    for (int i = N-1; i >= 0; i--)
      if (!vld[i]) victim = IW'(i);
  end

  // R8: ages remain a permutation, exactly one least-recent entry
  a_r8_single_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(oldest) == 1);
endmodule

// File: rtl/loop_trip_predictor.sv
module loop_trip_predictor
  import lp_pkg::*;
#(
  parameter int ENTRIES  = 8,
  parameter int MIN_TRIP = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lkp_valid,
  input  logic [LP_PC_W-1:0] lkp_pc,
  input  logic               lkp_backward,
  input  logic               lkp_base_taken,
  output logic               pred_taken,
  output logic               pred_override,
  input  logic               upd_valid,
  input  logic [LP_PC_W-1:0] upd_pc,
  input  logic               upd_backward,
  input  logic               upd_taken
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [LP_CNT_W-1:0] CNT_MAX  = {LP_CNT_W{1'b1}};
  localparam logic [LP_CNT_W-1:0] MIN_OBS  = LP_CNT_W'(MIN_TRIP - 1);

  lp_entry_t tbl [ENTRIES];
  lp_entry_t nxt, l_ent, u_ent;

  logic [ENTRIES-1:0]         vld_vec, l_hits, u_hits;
  logic [ENTRIES*LP_PC_W-1:0] tag_flat;
  logic                       l_any, u_any, upd_go, alloc, touch;
  logic [IDX_W-1:0]           l_idx, u_idx, victim, wr_idx;

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      vld_vec[i] = tbl[i].vld;
      tag_flat[i*LP_PC_W +: LP_PC_W] = tbl[i].tag;
    end
  end

  lp_cam #(.N(ENTRIES), .W(LP_PC_W)) u_cam_lkp (
    .clk(clk), .rst_n(rst_n), .vld(vld_vec), .tags(tag_flat), .key(lkp_pc),
    .hits(l_hits), .any(l_any), .idx(l_idx));

  lp_cam #(.N(ENTRIES), .W(LP_PC_W)) u_cam_upd (
    .clk(clk), .rst_n(rst_n), .vld(vld_vec), .tags(tag_flat), .key(upd_pc),
    .hits(u_hits), .any(u_any), .idx(u_idx));

  lp_repl #(.N(ENTRIES)) u_repl (
    .clk(clk), .rst_n(rst_n), .vld(vld_vec), .touch(touch),
    .touch_idx(wr_idx), .victim(victim));

  // lookup path: pure read of current state
  always_comb begin
    l_ent         = tbl[l_idx];
    pred_override = lkp_valid && lkp_backward && l_any && l_ent.conf;
    pred_taken    = pred_override ? (l_ent.iter < l_ent.trip) : lkp_base_taken;
  end

  // update path: next value of the written entry
  assign upd_go = upd_valid && upd_backward;
  assign alloc  = upd_go && !u_any && upd_taken;
  assign touch  = (upd_go && u_any) || alloc;
  assign wr_idx = u_any ? u_idx : victim;

  always_comb begin
    u_ent = tbl[u_idx];
    nxt   = u_ent;
    if (alloc) begin
      nxt.vld  = 1'b1;
      nxt.conf = 1'b0;
      nxt.tag  = upd_pc;
      nxt.trip = '0;
      nxt.iter = LP_CNT_W'(1);
    end else if (upd_taken) begin
      if (u_ent.iter == CNT_MAX) nxt.vld  = 1'b0;
      else                       nxt.iter = u_ent.iter + 1'b1;
    end else if (u_ent.iter < MIN_OBS) begin
      nxt.vld = 1'b0;
    end else begin
      nxt.conf = (u_ent.trip == u_ent.iter) && (u_ent.trip != '0);
      nxt.trip = u_ent.iter;
      nxt.iter = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
    end else if (touch) begin
      tbl[wr_idx] <= nxt;
    end
  end

  // R5/R10: an override needs a valid backward lookup
  a_r10_ovr_needs_bwd: assert property (@(posedge clk) disable iff (!rst_n)
    pred_override |-> (lkp_valid && lkp_backward));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    // R3: saturating iteration count frees the entry
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_go && u_any && u_idx == IDX_W'(g) && upd_taken && tbl[g].iter == CNT_MAX)
      |=> !tbl[g].vld);
    // R4/R7: a confident entry carries a trip value of a tracked loop
    a_r4_conf_trip: assert property (@(posedge clk) disable iff (!rst_n)
      (tbl[g].vld && tbl[g].conf) |-> (tbl[g].trip >= MIN_OBS));
  end
endmodule

// File: tb/tb_loop_trip_predictor.sv
module tb_loop_trip_predictor;
  localparam int NE = 8;
  localparam int MINT = 4;
  localparam int CMAX = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lkp_valid = 0, lkp_backward = 0, lkp_base_taken = 0;
  logic [31:0] lkp_pc = '0, upd_pc = '0;
  logic upd_valid = 0, upd_backward = 0, upd_taken = 0;
  logic pred_taken, pred_override;

  always #5 clk = ~clk;

  loop_trip_predictor dut (
    .clk(clk), .rst_n(rst_n), .lkp_valid(lkp_valid), .lkp_pc(lkp_pc),
    .lkp_backward(lkp_backward), .lkp_base_taken(lkp_base_taken),
    .pred_taken(pred_taken), .pred_override(pred_override),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_backward(upd_backward),
    .upd_taken(upd_taken));

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // behavioural table model
  bit m_v[NE]; bit m_c[NE];
  int m_tag[NE]; int m_trip[NE]; int m_iter[NE];
  int lru[$];

  function automatic int m_find(int pc);
    for (int i = 0; i < NE; i++) if (m_v[i] && m_tag[i] == pc) return i;
    return -1;
  endfunction

  function automatic void m_touch(int k);
    for (int i = 0; i < lru.size(); i++) if (lru[i] == k) begin lru.delete(i); break; end
    lru.push_front(k);
  endfunction

  function automatic void m_update(int pc, bit bwd, bit tk);
    int h, vic;
    if (!bwd) return;
    h = m_find(pc);
    if (h >= 0) begin
      m_touch(h);
      if (tk) begin
        if (m_iter[h] == CMAX) m_v[h] = 0; else m_iter[h]++;
      end else if (m_iter[h] < MINT - 1) m_v[h] = 0;
      else begin
        m_c[h] = (m_trip[h] == m_iter[h]) && (m_trip[h] != 0);
        m_trip[h] = m_iter[h];
        m_iter[h] = 0;
      end
    end else if (tk) begin
      vic = lru[lru.size() - 1];
      for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) vic = i;
      m_v[vic] = 1; m_c[vic] = 0; m_tag[vic] = pc; m_trip[vic] = 0; m_iter[vic] = 1;
      m_touch(vic);
    end
  endfunction

  task automatic chk(string tag, logic got, logic exp, string what);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // one cycle: drive, compare against model (and optional literal), clock, update model
  task automatic step(string tag, bit lv, int lpc, bit lb, bit base,
                      bit uv, int upc, bit ub, bit ut,
                      bit lit = 0, bit e_ovr = 0, bit e_pred = 0);
    int h; bit x_ovr, x_pred;
    lkp_valid = lv; lkp_pc = lpc; lkp_backward = lb; lkp_base_taken = base;
    upd_valid = uv; upd_pc = upc; upd_backward = ub; upd_taken = ut;
    #1;
    h = m_find(lpc);
    x_ovr  = lv && lb && (h >= 0) && m_c[h];
    x_pred = x_ovr ? (m_iter[h] < m_trip[h]) : base;
    chk({tag, "/model"}, pred_override, x_ovr, "override");
    chk({tag, "/model"}, pred_taken, x_pred, "pred");
    if (lit) begin
      chk(tag, pred_override, e_ovr, "override");
      chk(tag, pred_taken, e_pred, "pred");
    end
    @(posedge clk);
    if (uv) m_update(upc, ub, ut);
    @(negedge clk);
  endtask

  task automatic probe(string tag, int pc, bit base, bit e_ovr, bit e_pred);
    step(tag, 1, pc, 1, base, 0, 0, 0, 0, 1, e_ovr, e_pred);
  endtask

  task automatic loop_run(string tag, int pc, int n);
    for (int k = 0; k < n; k++) step(tag, 1, pc, 1, 1, 1, pc, 1, k < n - 1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog: got hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NE; i++) begin m_v[i] = 0; lru.push_back(i); end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: empty table after reset
    probe("R1", 32'h100, 1, 0, 1);
    probe("R1", 32'h100, 0, 0, 0);

    // R4: one invocation is not enough, two equal ones give confidence
    loop_run("R4", 32'h100, 6);
    probe("R4", 32'h100, 0, 0, 0);
    loop_run("R4", 32'h100, 6);
    probe("R4", 32'h100, 0, 1, 1);

    // R5: taken until the count reaches the trip, then not-taken
    for (int k = 0; k < 5; k++) step("R5", 1, 32'h100, 1, 1, 1, 32'h100, 1, 1, 1, 1, 1);
    probe("R5", 32'h100, 1, 1, 0);
    step("R5", 1, 32'h100, 1, 1, 1, 32'h100, 1, 0, 1, 1, 0);

    // R6: a different trip count drops confidence
    loop_run("R6", 32'h100, 8);
    probe("R6", 32'h100, 0, 0, 0);
    loop_run("R6", 32'h100, 8);
    probe("R6", 32'h100, 0, 1, 1);

    // R10: invalid or forward lookups never override
    step("R10", 1, 32'h100, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R10", 0, 32'h100, 1, 0, 0, 0, 0, 0, 1, 0, 0);

    // R7: three executions untracked, four executions tracked
    loop_run("R7", 32'h200, 3);
    loop_run("R7", 32'h200, 3);
    loop_run("R7", 32'h200, 3);
    probe("R7", 32'h200, 0, 0, 0);
    loop_run("R7", 32'h300, 4);
    loop_run("R7", 32'h300, 4);
    probe("R7", 32'h300, 1, 1, 1);

    // R2: forward updates and not-taken misses allocate nothing
    for (int r = 0; r < 3; r++)
      for (int k = 0; k < 6; k++) step("R2", 0, 0, 0, 0, 1, 32'h400, 0, k < 5);
    probe("R2", 32'h400, 1, 0, 1);
    step("R2", 0, 0, 0, 0, 1, 32'h500, 1, 0);
    loop_run("R2", 32'h500, 1);
    probe("R2", 32'h500, 0, 0, 0);

    // R9: same-cycle lookup sees pre-update count (trip 7 on 0x100)
    for (int k = 0; k < 6; k++) step("R9", 1, 32'h100, 1, 0, 1, 32'h100, 1, 1);
    step("R9", 1, 32'h100, 1, 0, 1, 32'h100, 1, 1, 1, 1, 1);
    probe("R9", 32'h100, 1, 1, 0);
    step("R9", 1, 32'h100, 1, 1, 1, 32'h100, 1, 0, 1, 1, 0);

    // R8: fill with eight new loops, then one more evicts the oldest
    for (int p = 0; p < 8; p++) begin
      loop_run("R8", 32'h1000 + p * 16, 5);
      loop_run("R8", 32'h1000 + p * 16, 5);
    end
    probe("R8", 32'h100, 0, 0, 0);
    probe("R8", 32'h300, 0, 0, 0);
    probe("R8", 32'h1000, 1, 1, 1);
    loop_run("R8", 32'h2000, 5);
    loop_run("R8", 32'h2000, 5);
    probe("R8", 32'h1000, 0, 0, 0);
    probe("R8", 32'h1010, 0, 1, 1);
    probe("R8", 32'h2000, 0, 1, 1);

    // R3: count overflow removes a confident entry
    loop_run("R3", 32'h600, 6);
    loop_run("R3", 32'h600, 6);
    probe("R3", 32'h600, 0, 1, 1);
    for (int k = 0; k < 1024; k++) step("R3", 0, 0, 0, 0, 1, 32'h600, 1, 1);
    probe("R3", 32'h600, 0, 0, 0);
    step("R3", 0, 0, 0, 0, 1, 32'h600, 1, 0);
    loop_run("R3", 32'h600, 6);
    probe("R3", 32'h600, 0, 0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule